// File: doc/BRIEF.md
# Kernel Scheduling Framework Tables

This block keeps the bookkeeping that sits between the per-context command inputs of a GPU execution engine and the unit that issues thread blocks to cores. Launch commands arrive from the command dispatcher on one shared port and carry a context number. Each context owns a command buffer that holds exactly one command. When a context's buffer is occupied, its input is back-pressured.

A scheduling policy admits a buffered command. Admission moves the command into a free slot of the kernel status table and appends that slot's number to the active queue. The active queue is the ordered list of kernels that are running or preempted. Each table slot holds the owning context, the total block count, the index of the next block to issue, the number of resident blocks, a per-block resource descriptor and a priority. This lets kernels from several processes be tracked side by side.

The policy walks the active queue through a scan index and reads back the matching slot number and record. The block issuer reports issued blocks and finished blocks per slot. A kernel with every block issued and none resident is retired automatically. Retirement frees its slot and removes it from the queue in one edge.

Top module: `skf_tables`

## Requirements
- R1: `cmd_ready` is high exactly when the buffer of context `cmd_ctx` is empty. A command offered with `cmd_valid` and `cmd_ready` is stored, and `buf_full` bit `cmd_ctx` is high from the next cycle.
- R2: A full buffer accepts nothing new. A command offered to it is dropped, and the buffered command stays intact, as later seen in the admitted record.
- R3: `admit_ack` is high exactly when `admit_req` is high, the buffer of `admit_ctx` is full and `q_count` is below the queue depth. On an acknowledged admission that buffer is empty from the next cycle.
- R4: An admission takes the lowest-numbered free table slot, reported on `admit_slot`. The new record holds context `admit_ctx`, total equal to the buffered block count, next index 0, resident count 0, and the buffered resource descriptor and priority.
- R5: The admitted slot number is appended at the tail of the active queue, and `q_count` grows by one.
- R6: `issue_req` on a valid slot whose next index is below its total increments both the next index and the resident count. Otherwise it has no effect.
- R7: `done_req` on a valid slot with a nonzero resident count decrements the resident count. Otherwise it has no effect.
- R8: A valid slot whose next index equals its total and whose resident count is 0 raises `retire_valid`, with `retire_slot` naming it. If several slots qualify, the lowest-numbered one is named. At the following edge that slot becomes free and its entry leaves the active queue, and the entries behind it move one place forward in order.
- R9: When an admission and a retirement fall in the same cycle, both take effect. `q_count` is unchanged, and the new slot sits at the tail of the compacted queue.
- R10: While `q_count` equals the queue depth, `admit_ack` stays low and the requested buffer stays full.
- R11: After reset all buffers are empty, `q_count` is 0, no slot is valid and `retire_valid` is low.
- R12: For `scan_idx` below `q_count`, `scan_valid` is high, and `scan_slot` and the `scan_*` fields give the queue entry at that position and its record. Otherwise `scan_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Dispatcher offers a launch command |
| cmd_ctx | input | 2 | Context of the offered command |
| cmd_blocks | input | 8 | Block count of the offered command |
| cmd_res | input | 6 | Per-block resource descriptor |
| cmd_prio | input | 3 | Priority of the offered command |
| cmd_ready | output | 1 | Buffer of `cmd_ctx` can take the command |
| buf_full | output | 4 | Per-context buffer occupied flags |
| admit_req | input | 1 | Policy requests admission |
| admit_ctx | input | 2 | Context whose buffered command is admitted |
| admit_ack | output | 1 | Admission is taken this cycle |
| admit_slot | output | 2 | Table slot allocated to the admission |
| issue_req | input | 1 | Issuer dispatched one block |
| issue_slot | input | 2 | Slot of the dispatched block |
| done_req | input | 1 | A resident block finished |
| done_slot | input | 2 | Slot of the finished block |
| scan_idx | input | 2 | Queue position read by the policy |
| scan_valid | output | 1 | Position holds an active kernel |
| scan_slot | output | 2 | Slot number at that position |
| scan_ctx | output | 2 | Owning context of the scanned kernel |
| scan_total | output | 8 | Total block count |
| scan_next | output | 8 | Next block index |
| scan_resident | output | 8 | Resident block count |
| scan_res | output | 6 | Resource descriptor |
| scan_prio | output | 3 | Priority |
| retire_valid | output | 1 | A kernel is retiring this cycle |
| retire_slot | output | 2 | Slot being retired |
| q_count | output | 3 | Active queue occupancy |

## Verification
Admission and retirement can meet in one cycle, and this is the case that stresses the queue. Admission appends at the tail while retirement compacts from the middle. A directed sequence provokes it by finishing a one-block kernel so that its retirement cycle is the cycle in which the policy admits another context's command. Random traffic then produces the same overlap many more times. The bench judges it by comparing `q_count`, the allocated slot and every queue position read through the scan port against an ordered-list model, and it counts that such overlaps actually occurred.

// File: rtl/skf_pkg.sv
package skf_pkg;
    parameter int NCTX   = 4;
    parameter int NSLOT  = 4;
    parameter int BLK_W  = 8;
    parameter int RES_W  = 6;
    parameter int PRIO_W = 3;

    localparam int CTX_W  = $clog2(NCTX);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int CNT_W  = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [RES_W-1:0]  res;
        logic [PRIO_W-1:0] prio;
        logic [BLK_W-1:0]  blocks;
    } cmd_t;

    typedef struct packed {
        logic              valid;
        logic [CTX_W-1:0]  ctx;
        logic [BLK_W-1:0]  total;
        logic [BLK_W-1:0]  next;
        logic [BLK_W-1:0]  resident;
        logic [RES_W-1:0]  res;
        logic [PRIO_W-1:0] prio;
    } rec_t;

    function automatic logic [SLOT_W-1:0] lowest_set(input logic [NSLOT-1:0] v);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (v[i]) r = SLOT_W'(i);
        return r;
    endfunction

    function automatic rec_t fresh_rec(input logic [CTX_W-1:0] c, input cmd_t k);
        rec_t r;
        r          = '0;
        r.valid    = 1'b1;
        r.ctx      = c;
        r.total    = k.blocks;
        r.res      = k.res;
        r.prio     = k.prio;
        return r;
    endfunction
endpackage

// File: rtl/skf_cmdbuf.sv
module skf_cmdbuf
    import skf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CTX_W-1:0]  in_ctx,
    input  cmd_t              in_cmd,
    output logic              in_ready,
    input  logic              take,
    input  logic [CTX_W-1:0]  take_ctx,
    output logic [NCTX-1:0]   full,
    output cmd_t              take_cmd
);
    cmd_t store [NCTX];

    assign in_ready = !full[in_ctx];
    assign take_cmd = store[take_ctx];

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic occ_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q    <= 1'b0;
                store[c] <= '0;
            end else if (in_valid && !occ_q && in_ctx == CTX_W'(c)) begin
                occ_q    <= 1'b1;
                store[c] <= in_cmd;
            end else if (take && take_ctx == CTX_W'(c)) begin
                occ_q    <= 1'b0;
            end
        end
        assign full[c] = occ_q;
    end
endmodule

// File: rtl/skf_kstab.sv
module skf_kstab
    import skf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  rec_t              wr_rec,
    input  logic              issue_req,
    input  logic [SLOT_W-1:0] issue_slot,
    input  logic              done_req,
    input  logic [SLOT_W-1:0] done_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output rec_t              rd_rec,
    output logic [SLOT_W-1:0] free_slot,
    output logic              ret_valid,
    output logic [SLOT_W-1:0] ret_slot
);
    rec_t             tab    [NSLOT];
    rec_t             tab_nx [NSLOT];
    logic [NSLOT-1:0] used;
    logic [NSLOT-1:0] finished;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            used[i]     = tab[i].valid;
            finished[i] = tab[i].valid && tab[i].next == tab[i].total
                          && tab[i].resident == '0;
        end
    end

    assign free_slot = lowest_set(~used);
    assign ret_valid = |finished;
    assign ret_slot  = lowest_set(finished);
    assign rd_rec    = tab[rd_slot];

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            logic up, dn;
            up = issue_req && issue_slot == SLOT_W'(i) && tab[i].valid
                 && tab[i].next < tab[i].total;
            dn = done_req && done_slot == SLOT_W'(i) && tab[i].valid
                 && tab[i].resident != '0;
            tab_nx[i]          = tab[i];
            tab_nx[i].next     = tab[i].next + BLK_W'(up);
            tab_nx[i].resident = tab[i].resident + BLK_W'(up) - BLK_W'(dn);
            if (ret_valid && ret_slot == SLOT_W'(i)) tab_nx[i].valid = 1'b0;
            if (wr_en && wr_slot == SLOT_W'(i))      tab_nx[i] = wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++)
            tab[i] <= rst ? '0 : tab_nx[i];
    end
endmodule

// File: rtl/skf_actq.sv
module skf_actq
    import skf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              rem,
    input  logic [SLOT_W-1:0] rem_slot,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [CNT_W-1:0]  count
);
    logic [SLOT_W-1:0] q    [NSLOT];
    logic [SLOT_W-1:0] q_nx [NSLOT];
    logic [CNT_W-1:0]  cnt_mid;
    logic [CNT_W-1:0]  pos;

    assign rd_slot = q[rd_idx];

    always_comb begin
        pos = CNT_W'(NSLOT);
        for (int i = NSLOT - 1; i >= 0; i--)
            if (CNT_W'(i) < count && q[i] == rem_slot) pos = CNT_W'(i);
        cnt_mid = count - CNT_W'(rem);
        for (int i = 0; i < NSLOT; i++) begin
            q_nx[i] = q[i];
            if (rem && CNT_W'(i) >= pos && i < NSLOT - 1) q_nx[i] = q[(i + 1) % NSLOT];
            if (push && CNT_W'(i) == cnt_mid)              q_nx[i] = push_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < NSLOT; i++) q[i] <= '0;
        end else begin
            count <= cnt_mid + CNT_W'(push);
            for (int i = 0; i < NSLOT; i++) q[i] <= q_nx[i];
        end
    end
endmodule

// File: rtl/skf_tables.sv
module skf_tables
    import skf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic [BLK_W-1:0]  cmd_blocks,
    input  logic [RES_W-1:0]  cmd_res,
    input  logic [PRIO_W-1:0] cmd_prio,
    output logic              cmd_ready,
    output logic [NCTX-1:0]   buf_full,
    input  logic              admit_req,
    input  logic [CTX_W-1:0]  admit_ctx,
    output logic              admit_ack,
    output logic [SLOT_W-1:0] admit_slot,
    input  logic              issue_req,
    input  logic [SLOT_W-1:0] issue_slot,
    input  logic              done_req,
    input  logic [SLOT_W-1:0] done_slot,
    input  logic [SLOT_W-1:0] scan_idx,
    output logic              scan_valid,
    output logic [SLOT_W-1:0] scan_slot,
    output logic [CTX_W-1:0]  scan_ctx,
    output logic [BLK_W-1:0]  scan_total,
    output logic [BLK_W-1:0]  scan_next,
    output logic [BLK_W-1:0]  scan_resident,
    output logic [RES_W-1:0]  scan_res,
    output logic [PRIO_W-1:0] scan_prio,
    output logic              retire_valid,
    output logic [SLOT_W-1:0] retire_slot,
    output logic [CNT_W-1:0]  q_count
);
    cmd_t in_cmd, head_cmd;
    rec_t scan_rec;

    assign in_cmd = '{res: cmd_res, prio: cmd_prio, blocks: cmd_blocks};

    skf_cmdbuf u_buf (
        .clk(clk), .rst(rst),
        .in_valid(cmd_valid), .in_ctx(cmd_ctx), .in_cmd(in_cmd), .in_ready(cmd_ready),
        .take(admit_ack), .take_ctx(admit_ctx), .full(buf_full), .take_cmd(head_cmd)
    );

    assign admit_ack = admit_req && buf_full[admit_ctx] && q_count != CNT_W'(NSLOT);

    skf_kstab u_tab (
        .clk(clk), .rst(rst),
        .wr_en(admit_ack), .wr_slot(admit_slot), .wr_rec(fresh_rec(admit_ctx, head_cmd)),
        .issue_req(issue_req), .issue_slot(issue_slot),
        .done_req(done_req), .done_slot(done_slot),
        .rd_slot(scan_slot), .rd_rec(scan_rec),
        .free_slot(admit_slot), .ret_valid(retire_valid), .ret_slot(retire_slot)
    );

    skf_actq u_q (
        .clk(clk), .rst(rst),
        .push(admit_ack), .push_slot(admit_slot),
        .rem(retire_valid), .rem_slot(retire_slot),
        .rd_idx(scan_idx), .rd_slot(scan_slot), .count(q_count)
    );

    assign scan_valid    = CNT_W'(scan_idx) < q_count;
    assign scan_ctx      = scan_rec.ctx;
    assign scan_total    = scan_rec.total;
    assign scan_next     = scan_rec.next;
    assign scan_resident = scan_rec.resident;
    assign scan_res      = scan_rec.res;
    assign scan_prio     = scan_rec.prio;
endmodule

module skf_tables_chk
    import skf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [CTX_W-1:0]  cmd_ctx,
    input logic              cmd_ready,
    input logic [NCTX-1:0]   buf_full,
    input logic              admit_ack,
    input logic [CTX_W-1:0]  admit_ctx,
    input logic              retire_valid,
    input logic [CNT_W-1:0]  q_count
);
    // R1
    cmd_stored_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> buf_full[$past(cmd_ctx)]);
    // R3
    admit_drains_chk: assert property (@(posedge clk) disable iff (rst)
        admit_ack |=> !buf_full[$past(admit_ctx)]);
    // R5
    admit_grows_chk: assert property (@(posedge clk) disable iff (rst)
        admit_ack && !retire_valid |=> q_count == $past(q_count) + CNT_W'(1));
    // R8
    retire_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        retire_valid && !admit_ack |=> q_count == $past(q_count) - CNT_W'(1));
    // R9
    both_balance_chk: assert property (@(posedge clk) disable iff (rst)
        admit_ack && retire_valid |=> q_count == $past(q_count));
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(NSLOT));
endmodule

bind skf_tables skf_tables_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ctx(cmd_ctx),
    .cmd_ready(cmd_ready), .buf_full(buf_full), .admit_ack(admit_ack),
    .admit_ctx(admit_ctx), .retire_valid(retire_valid), .q_count(q_count)
);

// File: tb/tb_skf_tables.sv
module tb_skf_tables;
    import skf_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 0, admit_req = 0, issue_req = 0, done_req = 0;
    logic [CTX_W-1:0]  cmd_ctx = '0, admit_ctx = '0;
    logic [BLK_W-1:0]  cmd_blocks = '0;
    logic [RES_W-1:0]  cmd_res = '0;
    logic [PRIO_W-1:0] cmd_prio = '0;
    logic [SLOT_W-1:0] issue_slot = '0, done_slot = '0, scan_idx = '0;
    logic cmd_ready, admit_ack, scan_valid, retire_valid;
    logic [NCTX-1:0]   buf_full;
    logic [SLOT_W-1:0] admit_slot, scan_slot, retire_slot;
    logic [CTX_W-1:0]  scan_ctx;
    logic [BLK_W-1:0]  scan_total, scan_next, scan_resident;
    logic [RES_W-1:0]  scan_res;
    logic [PRIO_W-1:0] scan_prio;
    logic [CNT_W-1:0]  q_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    skf_tables dut (.*);

    int total = 0, bad = 0, both_seen = 0;
    bit mfull [NCTX];
    int b_blk [NCTX], b_res [NCTX], b_prio [NCTX];
    bit mv [NSLOT];
    int mctx [NSLOT], mtot [NSLOT], mnext [NSLOT], mresd [NSLOT], mres [NSLOT], mprio [NSLOT];
    int mq [NSLOT];
    int mcnt = 0;

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < NSLOT; i++) if (!mv[i]) return i;
        return 0;
    endfunction

    function automatic int low_done();
        for (int i = 0; i < NSLOT; i++)
            if (mv[i] && mnext[i] == mtot[i] && mresd[i] == 0) return i;
        return -1;
    endfunction

    // one cycle: inputs are already driven after a falling edge
    task automatic step();
        bit e_ready, e_ack;
        int e_slot, e_ret;
        bit up [NSLOT];
        bit dn [NSLOT];
        #1;
        e_ready = !mfull[cmd_ctx];
        e_ack   = admit_req && mfull[admit_ctx] && mcnt < NSLOT;
        e_slot  = low_free();
        e_ret   = low_done();
        chk("R1 cmd_ready", cmd_ready, e_ready);
        for (int c = 0; c < NCTX; c++) chk("R1 buf_full", buf_full[c], mfull[c]);
        chk(mcnt == NSLOT ? "R10 admit_ack when full" : "R3 admit_ack", admit_ack, e_ack);
        if (e_ack) chk("R4 admit_slot", admit_slot, e_slot);
        chk("R8 retire_valid", retire_valid, e_ret >= 0);
        if (e_ret >= 0) chk("R8 retire_slot", retire_slot, e_ret);
        chk("R5 q_count", q_count, mcnt);
        chk("R12 scan_valid", scan_valid, scan_idx < mcnt);
        if (scan_idx < mcnt) begin
            int s = mq[scan_idx];
            chk("R12 scan_slot", scan_slot, s);
            chk("R4 scan_ctx", scan_ctx, mctx[s]);
            chk("R4 scan_total", scan_total, mtot[s]);
            chk("R6 scan_next", scan_next, mnext[s]);
            chk("R7 scan_resident", scan_resident, mresd[s]);
            chk("R2 scan_res", scan_res, mres[s]);
            chk("R4 scan_prio", scan_prio, mprio[s]);
        end
        if (e_ack && e_ret >= 0) both_seen++;
        for (int i = 0; i < NSLOT; i++) begin
            up[i] = issue_req && issue_slot == i && mv[i] && mnext[i] < mtot[i];
            dn[i] = done_req && done_slot == i && mv[i] && mresd[i] > 0;
        end
        for (int i = 0; i < NSLOT; i++) begin
            mnext[i] += up[i];
            mresd[i] += int'(up[i]) - int'(dn[i]);
        end
        if (e_ret >= 0) begin
            int p = 0;
            for (int i = 0; i < mcnt; i++) if (mq[i] == e_ret) p = i;
            for (int i = p; i < mcnt - 1; i++) mq[i] = mq[i + 1];
            mcnt--;
            mv[e_ret] = 0;
        end
        if (e_ack) begin
            mv[e_slot] = 1; mctx[e_slot] = admit_ctx; mtot[e_slot] = b_blk[admit_ctx];
            mnext[e_slot] = 0; mresd[e_slot] = 0;
            mres[e_slot] = b_res[admit_ctx]; mprio[e_slot] = b_prio[admit_ctx];
            mq[mcnt] = e_slot; mcnt++;
            mfull[admit_ctx] = 0;
        end
        if (cmd_valid && e_ready) begin
            mfull[cmd_ctx] = 1; b_blk[cmd_ctx] = cmd_blocks;
            b_res[cmd_ctx] = cmd_res; b_prio[cmd_ctx] = cmd_prio;
        end
        @(negedge clk);
        cmd_valid = 0; admit_req = 0; issue_req = 0; done_req = 0;
    endtask

    task automatic put(input int c, input int blk, input int r, input int p);
        cmd_valid = 1; cmd_ctx = CTX_W'(c); cmd_blocks = BLK_W'(blk);
        cmd_res = RES_W'(r); cmd_prio = PRIO_W'(p);
        step();
    endtask

    task automatic adm(input int c);
        admit_req = 1; admit_ctx = CTX_W'(c);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        chk("R11 q_count", q_count, 0);
        chk("R11 buf_full", buf_full, 0);
        chk("R11 retire_valid", retire_valid, 0);
        chk("R11 cmd_ready", cmd_ready, 1);
        // fill buffers; slot0 kernel has one block
        put(0, 1, 11, 1); put(1, 5, 12, 2); put(2, 5, 13, 3); put(3, 5, 14, 4);
        put(0, 9, 60, 7);                 // R2 dropped: buffer of ctx0 full
        adm(0); adm(1); adm(2);           // slots 0,1,2
        issue_req = 1; issue_slot = 0; step();   // R6
        issue_req = 1; issue_slot = 0; step();   // R6 ignored, next==total
        done_req = 1; done_slot = 0; step();     // R7
        adm(3);                           // R9 admission in retire cycle
        put(0, 5, 21, 5); adm(0);         // queue reaches full
        put(2, 3, 22, 6); adm(2);         // R10 blocked
        chk("R10 buf stays full", buf_full[2], 1);
        chk("R9 coincidence seen", both_seen > 0, 1);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            cmd_valid  = ($urandom % 2) == 0;
            cmd_ctx    = CTX_W'($urandom);
            cmd_blocks = BLK_W'($urandom % 4);
            cmd_res    = RES_W'($urandom);
            cmd_prio   = PRIO_W'($urandom);
            admit_req  = ($urandom % 5) < 2;
            admit_ctx  = CTX_W'($urandom);
            issue_req  = ($urandom % 2) == 0;
            issue_slot = SLOT_W'($urandom);
            done_req   = ($urandom % 2) == 0;
            done_slot  = SLOT_W'($urandom);
            scan_idx   = SLOT_W'($urandom);
            step();
        end
        chk("R9 random coincidences", both_seen > 1, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule